// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block is the software-visible register set of a two-channel storage bus-master DMA controller. It decodes a 16-byte I/O window in which each channel owns an 8-byte slice. Each slice holds a command byte, a status byte and a 32-bit pointer to the transfer descriptor table. Software reaches the registers through a single-cycle read/write strobe interface. That interface carries a byte address, a right-justified data bus and a size code.

The current command, status and pointer values go out on flat output buses to a separate DMA engine. The engine reports back through three per-channel inputs: a level that marks a running transfer, and one-cycle pulses that raise the error and interrupt flags. When software sets the run bit, the block also gives the engine a one-cycle start pulse.

The command and status registers accept byte accesses only. The status byte mixes three kinds of bit: bits software writes directly, bits software clears by writing one, and a bit only the engine controls.

Top module: `bmdma_regs`

## Requirements
- R1: Addresses 0 to 7 select channel 0 and addresses 8 to 15 select channel 1. Within a slice, local offset 0 is command, 2 is status and 4 to 7 is the descriptor pointer. An access to one channel never changes the other.
- R2: A byte read (size code 0) returns the command byte at local offset 0 and the status byte at local offset 2. At local offsets 1 and 3 it returns 0x000000FF.
- R3: At local offsets 0 to 3, a write with size code 1 (halfword) or 2/3 (word) has no effect. A read with those codes returns 0x0000FFFF or 0xFFFFFFFF respectively.
- R4: A byte write to command stores data bit 0 (run) and data bit 3 (direction). All other command bits read 0.
- R5: A byte write that moves the command run bit from 0 to 1 drives that channel's start output high for exactly the following cycle. No other write produces a start pulse.
- R6: A byte write to status loads status bits 5 and 6 from data bits 5 and 6. Status bits 3, 4 and 7 always read 0.
- R7: Status bits 1 (error) and 2 (interrupt) are cleared by a byte status write with a 1 in that data bit. A 0 in that data bit leaves the flag unchanged.
- R8: Status bit 0 equals the channel's engine-active input as sampled at the previous clock edge. Software writes never change it.
- R9: An engine error or interrupt set pulse makes status bit 1 or 2 read 1 in the next cycle. This holds even when software clears that bit in the same cycle.
- R10: The descriptor pointer accepts a byte write at any of local offsets 4 to 7, a halfword write at offsets 4 and 6, and a word write at offset 4. Its bits 1:0 always read 0. Reads follow the same alignment rules and return the addressed lane right-justified. A misaligned access is ignored on write and reads all ones for its width.
- R11: Synchronous active-low reset clears command, status, pointer and start outputs of both channels to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe; rdata is valid combinationally in the same cycle |
| addr | input | 4 | Byte address inside the window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| wdata | input | 32 | Write data, right-justified |
| rdata | output | 32 | Read data, right-justified; zero when rd_en is low |
| eng_active | input | 2 | Per channel: transfer in progress |
| eng_err_set | input | 2 | Per channel: one-cycle pulse that raises the error flag |
| eng_irq_set | input | 2 | Per channel: one-cycle pulse that raises the interrupt flag |
| cmd_o | output | 16 | Command bytes, channel 0 in bits 7:0 |
| stat_o | output | 16 | Status bytes, channel 0 in bits 7:0 |
| prd_o | output | 64 | Descriptor pointers, channel 0 in bits 31:0 |
| start_o | output | 2 | Per channel one-cycle start pulse |

## Verification
On every cycle, the assertions check the following:
- the status active bit tracks the engine input with a one-cycle lag;
- set pulses land in the error and interrupt flags;
- the start pulse only follows a 0-to-1 change of the run bit;
- byte writes load the command and directly-written status bits;
- wide writes to the command byte and misaligned pointer writes leave the registers unchanged;
- filler offsets read 0xFF.

Only the bench scenarios can show the rest:
- channel isolation;
- merging of partial pointer writes into the full 32-bit value;
- lane extraction on reads;
- clear-by-one versus write-zero behaviour across successive writes;
- the outcome of a clear that collides with a set pulse;
- the effect of a reset in the middle of operation.

// File: rtl/bmdma_pkg.sv
// Shared constants, types and helpers for the bus-master DMA register file.
// Assumes right-justified data on a 32-bit bus and 8-byte channel slices.
package bmdma_pkg;

    localparam int REG_W      = 32;
    localparam int BYTE_W     = 8;
    localparam int SLICE      = 8;
    localparam int LOC_W      = $clog2(SLICE);
    localparam int LANES      = REG_W / BYTE_W;
    localparam int LANE_W     = $clog2(LANES);

    // Access size codes on the size port
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRSV = 2'd3
    } size_e;

    // Local offsets inside a slice (low two bits of the control half)
    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd2;

    // All-ones pattern for the width of an access
    function automatic logic [REG_W-1:0] width_ones(input size_e s);
        case (s)
            SZ_BYTE: width_ones = REG_W'({BYTE_W{1'b1}});
            SZ_HALF: width_ones = REG_W'({2*BYTE_W{1'b1}});
            default: width_ones = {REG_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
// Address decoder: splits a window address into a one-hot channel select
// and a local slice offset. Assumes NCH >= 2 so the channel field exists.
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH * SLICE)
) (
    input  logic [AW-1:0]    addr,
    output logic [NCH-1:0]   ch_hit,
    output logic [LOC_W-1:0] loc
);

    // Pick the slice and local offset from the byte address
    always_comb begin
        loc = addr[LOC_W-1:0];
        for (int i = 0; i < NCH; i++) begin
            ch_hit[i] = (int'(addr[AW-1:LOC_W]) == i);
        end
    end

endmodule

// File: rtl/bmdma_ctl.sv
// Command and status registers of one channel. Only byte accesses act on
// them; wider accesses are ignored on write and read as all ones.
// Assumes wr_stb is already qualified by the channel select.
module bmdma_ctl
    import bmdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [1:0]         loc,
    input  size_e              size,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               eng_active,
    input  logic               eng_err_set,
    input  logic               eng_irq_set,
    output logic [BYTE_W-1:0]  cmd,
    output logic [BYTE_W-1:0]  stat,
    output logic               start_pulse,
    output logic [REG_W-1:0]   rd_val
);

    logic       byte_acc;
    logic       cmd_we;
    logic       stat_we;
    logic       run_q;
    logic       dir_q;
    logic       start_q;
    logic       act_q;
    logic       err_q;
    logic       irq_q;
    logic [1:0] cap_q;
    logic       unused_w;

    assign byte_acc = (size == SZ_BYTE);
    assign cmd_we   = wr_stb && byte_acc && (loc == OFS_CMD);
    assign stat_we  = wr_stb && byte_acc && (loc == OFS_STAT);
    assign unused_w = ^{wdata[7], wdata[4]};

    // Command register: run and direction bits plus start edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            dir_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= cmd_we && wdata[0] && !run_q;
            if (cmd_we) begin
                run_q <= wdata[0];
                dir_q <= wdata[3];
            end
        end
    end

    // Status register: engine-owned, clear-by-one and direct bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= 2'b00;
        end else begin
            act_q <= eng_active;
            err_q <= (err_q && !(stat_we && wdata[1])) || eng_err_set;
            irq_q <= (irq_q && !(stat_we && wdata[2])) || eng_irq_set;
            if (stat_we) begin
                cap_q <= wdata[6:5];
            end
        end
    end

    assign cmd         = {4'b0000, dir_q, 2'b00, run_q};
    assign stat        = {1'b0, cap_q, 2'b00, irq_q, err_q, act_q};
    assign start_pulse = start_q;

    // Read view of the control half of the slice
    always_comb begin
        if (!byte_acc) begin
            rd_val = width_ones(size);
        end else begin
            case (loc)
                OFS_CMD:  rd_val = REG_W'(cmd);
                OFS_STAT: rd_val = REG_W'(stat);
                default:  rd_val = REG_W'({BYTE_W{1'b1}});
            endcase
        end
    end

endmodule

// File: rtl/bmdma_prd.sv
// Descriptor-table pointer of one channel. Accepts naturally aligned byte,
// halfword and word accesses; bits 1:0 are held at zero. Misaligned
// accesses are ignored on write and read as all ones.
module bmdma_prd
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [LANE_W-1:0] loc,
    input  size_e             size,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  prd,
    output logic [REG_W-1:0]  rd_val
);

    logic              aligned;
    logic [LANES-1:0]  lane_en;
    logic [REG_W-1:0]  wshift;
    logic [REG_W-1:0]  nxt;
    logic [REG_W-1:0]  prd_q;

    // Alignment check and lane enables for the access size
    always_comb begin
        case (size)
            SZ_BYTE: begin
                aligned = 1'b1;
                lane_en = LANES'(1) << loc;
            end
            SZ_HALF: begin
                aligned = !loc[0];
                lane_en = LANES'(3) << loc;
            end
            default: begin
                aligned = (loc == '0);
                lane_en = {LANES{1'b1}};
            end
        endcase
        wshift = wdata << {loc, 3'b000};
    end

    // Merge the written lanes into the held pointer
    always_comb begin
        nxt = prd_q;
        for (int b = 0; b < LANES; b++) begin
            if (lane_en[b]) begin
                nxt[b*BYTE_W +: BYTE_W] = wshift[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Pointer storage with the two low bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q <= '0;
        end else if (wr_stb && aligned) begin
            prd_q <= {nxt[REG_W-1:2], 2'b00};
        end
    end

    assign prd = prd_q;

    // Read view: addressed lane right-justified, or all ones if misaligned
    always_comb begin
        if (aligned) begin
            rd_val = (prd_q >> {loc, 3'b000}) & width_ones(size);
        end else begin
            rd_val = width_ones(size);
        end
    end

endmodule

// File: rtl/bmdma_regs.sv
// Top of the bus-master DMA register file: decodes the I/O window,
// instantiates one control and one pointer block per channel, and
// multiplexes combinational read data. Assumes single-cycle strobes
// and at most one of wr_en / rd_en per cycle.
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH * SLICE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [1:0]            size,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic [NCH-1:0]        eng_active,
    input  logic [NCH-1:0]        eng_err_set,
    input  logic [NCH-1:0]        eng_irq_set,
    output logic [NCH*BYTE_W-1:0] cmd_o,
    output logic [NCH*BYTE_W-1:0] stat_o,
    output logic [NCH*REG_W-1:0]  prd_o,
    output logic [NCH-1:0]        start_o
);

    size_e            sz;
    logic [NCH-1:0]   ch_hit;
    logic [LOC_W-1:0] loc;
    logic [REG_W-1:0] ctl_rd  [NCH];
    logic [REG_W-1:0] prd_rd  [NCH];
    logic [REG_W-1:0] chan_rd [NCH];

    assign sz = size_e'(size);

    bmdma_decode #(.NCH(NCH)) u_dec (
        .addr   (addr),
        .ch_hit (ch_hit),
        .loc    (loc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ctl_wr;
        logic prd_wr;

        assign ctl_wr = wr_en && ch_hit[c] && !loc[LOC_W-1];
        assign prd_wr = wr_en && ch_hit[c] &&  loc[LOC_W-1];

        bmdma_ctl u_ctl (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_stb      (ctl_wr),
            .loc         (loc[1:0]),
            .size        (sz),
            .wdata       (wdata[BYTE_W-1:0]),
            .eng_active  (eng_active[c]),
            .eng_err_set (eng_err_set[c]),
            .eng_irq_set (eng_irq_set[c]),
            .cmd         (cmd_o[c*BYTE_W +: BYTE_W]),
            .stat        (stat_o[c*BYTE_W +: BYTE_W]),
            .start_pulse (start_o[c]),
            .rd_val      (ctl_rd[c])
        );

        bmdma_prd u_prd (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (prd_wr),
            .loc    (loc[LANE_W-1:0]),
            .size   (sz),
            .wdata  (wdata),
            .prd    (prd_o[c*REG_W +: REG_W]),
            .rd_val (prd_rd[c])
        );

        // Choose between the control and pointer halves of the slice
        assign chan_rd[c] = loc[LOC_W-1] ? prd_rd[c] : ctl_rd[c];
    end

    // Read-data mux over the selected channel
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            rdata = width_ones(sz);
            for (int c = 0; c < NCH; c++) begin
                if (ch_hit[c]) begin
                    rdata = chan_rd[c];
                end
            end
        end
    end

endmodule

// File: rtl/bmdma_regs_chk.sv
// Property checker for bmdma_regs, attached by bind. Observes ports only.
module bmdma_regs_chk
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH * SLICE)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [AW-1:0]         addr,
    input logic [1:0]            size,
    input logic [REG_W-1:0]      wdata,
    input logic [REG_W-1:0]      rdata,
    input logic [NCH-1:0]        eng_active,
    input logic [NCH-1:0]        eng_err_set,
    input logic [NCH-1:0]        eng_irq_set,
    input logic [NCH*BYTE_W-1:0] cmd_o,
    input logic [NCH*BYTE_W-1:0] stat_o,
    input logic [NCH*REG_W-1:0]  prd_o,
    input logic [NCH-1:0]        start_o
);

    a_r2_filler_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && size == 2'd0 && !addr[2] && addr[0]) |-> rdata == 32'h0000_00FF);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [AW-1:0] A_CMD  = AW'(c * SLICE);
        localparam logic [AW-1:0] A_STAT = AW'(c * SLICE + 2);

        a_r3_wide_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && size != 2'd0 && addr == A_CMD) |=> $stable(cmd_o[c*BYTE_W +: BYTE_W]));

        a_r4_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && size == 2'd0 && addr == A_CMD) |=>
            (cmd_o[c*BYTE_W] == $past(wdata[0]) && cmd_o[c*BYTE_W+3] == $past(wdata[3])));

        a_r5_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[c] |-> (cmd_o[c*BYTE_W] && !$past(cmd_o[c*BYTE_W])));

        a_r6_direct_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && size == 2'd0 && addr == A_STAT) |=>
            stat_o[c*BYTE_W+5 +: 2] == $past(wdata[6:5]));

        a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && size == 2'd0 && addr == A_STAT && wdata[1] && !eng_err_set[c]) |=>
            !stat_o[c*BYTE_W+1]);

        a_r8_active_follow: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> stat_o[c*BYTE_W] == $past(eng_active[c]));

        a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
            eng_err_set[c] |=> stat_o[c*BYTE_W+1]);

        a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
            eng_irq_set[c] |=> stat_o[c*BYTE_W+2]);

        a_r10_misaligned_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(addr[AW-1:3]) == c && addr[2] &&
             ((size == 2'd1 && addr[0]) || (size[1] && addr[1:0] != 2'b00))) |=>
            $stable(prd_o[c*REG_W +: REG_W]));
    end

endmodule

bind bmdma_regs bmdma_regs_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd0,  2'd0, 32'h0000_00FF, 32'h0,          8'd4},  // R4 write
        '{1'b0, 4'd0,  2'd0, 32'h0,         32'h0000_0009,  8'd4},  // R4
        '{1'b0, 4'd1,  2'd0, 32'h0,         32'h0000_00FF,  8'd2},  // R2
        '{1'b0, 4'd3,  2'd0, 32'h0,         32'h0000_00FF,  8'd2},  // R2
        '{1'b0, 4'd0,  2'd1, 32'h0,         32'h0000_FFFF,  8'd3},  // R3
        '{1'b0, 4'd2,  2'd2, 32'h0,         32'hFFFF_FFFF,  8'd3},  // R3
        '{1'b1, 4'd0,  2'd1, 32'h0,         32'h0,          8'd3},  // R3 ignored
        '{1'b0, 4'd0,  2'd0, 32'h0,         32'h0000_0009,  8'd3},  // R3
        '{1'b1, 4'd2,  2'd0, 32'h0000_00FF, 32'h0,          8'd6},  // R6 write
        '{1'b0, 4'd2,  2'd0, 32'h0,         32'h0000_0060,  8'd6},  // R6
        '{1'b0, 4'd10, 2'd0, 32'h0,         32'h0000_0000,  8'd1},  // R1
        '{1'b0, 4'd8,  2'd0, 32'h0,         32'h0000_0000,  8'd1},  // R1
        '{1'b1, 4'd4,  2'd2, 32'h1234_5677, 32'h0,          8'd10}, // R10
        '{1'b0, 4'd4,  2'd2, 32'h0,         32'h1234_5674,  8'd10}, // R10
        '{1'b1, 4'd13, 2'd0, 32'h0000_00AB, 32'h0,          8'd10}, // R10
        '{1'b0, 4'd12, 2'd2, 32'h0,         32'h0000_AB00,  8'd10}, // R10
        '{1'b1, 4'd14, 2'd1, 32'h0000_CDEF, 32'h0,          8'd10}, // R10
        '{1'b0, 4'd14, 2'd1, 32'h0,         32'h0000_CDEF,  8'd10}, // R10
        '{1'b0, 4'd12, 2'd2, 32'h0,         32'hCDEF_AB00,  8'd10}, // R10
        '{1'b1, 4'd5,  2'd1, 32'h0000_1111, 32'h0,          8'd10}, // R10 misaligned
        '{1'b0, 4'd4,  2'd2, 32'h0,         32'h1234_5674,  8'd10}, // R10
        '{1'b0, 4'd5,  2'd1, 32'h0,         32'h0000_FFFF,  8'd10}, // R10
        '{1'b0, 4'd6,  2'd0, 32'h0,         32'h0000_0034,  8'd10}, // R10
        '{1'b0, 4'd7,  2'd0, 32'h0,         32'h0000_0012,  8'd10}, // R10
        '{1'b1, 4'd10, 2'd0, 32'h0000_0040, 32'h0,          8'd1},  // R1
        '{1'b0, 4'd10, 2'd0, 32'h0,         32'h0000_0040,  8'd1},  // R1
        '{1'b0, 4'd2,  2'd0, 32'h0,         32'h0000_0060,  8'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  eng_active = '0;
    logic [1:0]  eng_err_set = '0;
    logic [1:0]  eng_irq_set = '0;
    logic [15:0] cmd_o;
    logic [15:0] stat_o;
    logic [63:0] prd_o;
    logic [1:0]  start_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bmdma_regs uut (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .size, .wdata, .rdata,
        .eng_active, .eng_err_set, .eng_irq_set,
        .cmd_o, .stat_o, .prd_o, .start_o
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a; size = s;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 cmd", 64'(cmd_o), 64'h0);
        check("R11 stat", 64'(stat_o), 64'h0);
        check("R11 prd", prd_o, 64'h0);
        check("R11 start", 64'(start_o), 64'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].a, VEC[i].sz, VEC[i].d);
            end else begin
                rd(VEC[i].a, VEC[i].sz, v);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(v), 64'(VEC[i].exp));
            end
        end

        // R8: active bit follows engine, immune to software
        @(negedge clk); eng_active[0] = 1'b1;
        rd(4'd2, 2'd0, v);
        check("R8 active set", 64'(v), 64'h61);
        wr(4'd2, 2'd0, 32'h00);
        check("R8 sw write keeps active", 64'(stat_o[7:0]), 64'h01);
        eng_active[0] = 1'b0;
        @(negedge clk);
        check("R8 active cleared", 64'(stat_o[7:0]), 64'h00);

        // R9: engine set pulses
        eng_err_set[0] = 1'b1; @(negedge clk); eng_err_set[0] = 1'b0;
        check("R9 err set", 64'(stat_o[7:0]), 64'h02);
        eng_irq_set[0] = 1'b1; @(negedge clk); eng_irq_set[0] = 1'b0;
        check("R9 irq set", 64'(stat_o[7:0]), 64'h06);

        // R7: clear by one, zero leaves
        wr(4'd2, 2'd0, 32'h02);
        check("R7 clear err", 64'(stat_o[7:0]), 64'h04);
        wr(4'd2, 2'd0, 32'h00);
        check("R7 zero keeps irq", 64'(stat_o[7:0]), 64'h04);

        // R9: set wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd2; size = 2'd0; wdata = 32'h04; eng_irq_set[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; eng_irq_set[0] = 1'b0;
        check("R9 set beats clear", 64'(stat_o[7:0]), 64'h04);
        wr(4'd2, 2'd0, 32'h04);
        check("R7 clear irq", 64'(stat_o[7:0]), 64'h00);

        // R5: start pulse on rising run bit only
        wr(4'd8, 2'd0, 32'h01);
        check("R5 start pulse", 64'(start_o), 64'h2);
        @(negedge clk);
        check("R5 pulse one cycle", 64'(start_o), 64'h0);
        wr(4'd8, 2'd0, 32'h01);
        check("R5 no pulse when already set", 64'(start_o), 64'h0);
        wr(4'd8, 2'd0, 32'h00);
        check("R5 no pulse on clear", 64'(start_o), 64'h0);
        wr(4'd8, 2'd0, 32'h09);
        check("R5 pulse again", 64'(start_o), 64'h2);
        check("R4 ch1 cmd", 64'(cmd_o[15:8]), 64'h09);
        check("R1 ch0 cmd untouched", 64'(cmd_o[7:0]), 64'h09);

        // R3: wide write to command gives no pulse and no change
        wr(4'd8, 2'd0, 32'h00);
        wr(4'd8, 2'd1, 32'h01);
        check("R3 wide write no pulse", 64'(start_o), 64'h0);
        check("R3 wide write no change", 64'(cmd_o[15:8]), 64'h00);

        // R11: reset in mid-operation
        eng_active = 2'b11;
        @(negedge clk);
        do_reset();
        eng_active = 2'b00;
        check("R11 cmd after reset", 64'(cmd_o), 64'h0);
        check("R11 stat after reset", 64'(stat_o), 64'h0);
        check("R11 prd after reset", prd_o, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule